// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Controller

This block models the control side of a byte-wide memory that can be written only once per bit. Five control inputs select what it does. These are an active-low chip select, an active-low output enable, an active-low program strobe, a flag that says the programming supply is raised, and a flag that says the high-voltage identification level is present on the address line. Depending on these inputs, the block does one of four things:

- returns the byte stored at the address;
- merges the input byte into the stored byte;
- returns one of a small set of identification bytes;
- releases the data bus.

The storage is a register file with a depth set by a parameter. Every bit starts out erased to one. A program write can only pull bits to zero. A programmer therefore writes a byte, checks it in verify mode, and writes again if some bits did not clear. Bus release is modelled by an output-enable signal. While that signal is low, the data output is held at zero. Supply levels and access delays are outside the model.

Top module: `otp_mode_ctrl`

## Requirements
- R1: After reset every stored bit is one, so a read of any address returns 8'hFF.
- R2: A program write stores the old byte ANDed with the input byte. A bit that is zero never returns to one.
- R3: Read mode is selected when chip select is low, output enable is low, the programming supply flag is low and the ID flag is low. In read mode the output enable is high and the stored byte at the address is driven.
- R4: In every mode that does not drive data, the output enable is low and the data output is 8'h00. These modes are:
  - chip select high, whatever the other inputs are;
  - output enable input high with chip select low;
  - program mode;
  - any combination with the supply flag high that is neither program mode nor verify mode.
- R5: Program mode is selected when the supply flag is high, chip select is low, the strobe is low and output enable is high. In any other case no write happens, including when chip select is high with the supply flag high.
- R6: Verify mode is selected when the supply flag is high, chip select is low, output enable is low and the strobe is high. In verify mode the stored byte is driven.
- R7: ID mode is selected when the supply flag is low, the ID flag is high, and chip select and output enable are both low. In ID mode with address bit 1 high, address bit 0 low returns 8'h1C and address bit 0 high returns 8'h02.
- R8: In ID mode with address bit 1 low, the output is 8'h7F whatever address bit 0 is.
- R9: Every ID byte has an odd number of ones, with bit 7 serving as the parity bit.
- R10: A write takes place once, on the clock edge where the strobe is first sampled low after having been sampled high while in program mode. Holding the strobe low writes nothing more. A strobe that fell outside program mode writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | High-voltage ID level present |
| addr | input | ADDR_W | Byte address; bits 1 and 0 select the ID byte |
| din | input | 8 | Byte to program |
| dout | output | 8 | Data output, zero when released |
| dout_oe | output | 1 | High when the data output is driven |

## Verification
The embedded assertions check several properties on every cycle:
- at most one mode is decoded at a time;
- chip select high never drives the bus;
- no stored bit rises from zero to one;
- a write only happens with the pins in program mode, and never on two cycles in a row;
- every ID byte leaves with odd parity.

The bench's scenarios cover the rest. The actual ID values, the AND merge and the stored contents are compared against a bench memory model. Missed strobe edges are checked by reading back through verify and read modes after a strobe fell outside program mode or was held low. The bench also checks that programming is blocked while chip select is high.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_DISABLE,
    M_READ,
    M_PROGRAM,
    M_VERIFY,
    M_ID
  } otp_mode_e;

  // ID byte: 7 code bits plus bit 7 chosen for odd parity
  function automatic logic [BYTE_W-1:0] id_byte(input logic a1, input logic a0,
                                                input logic [6:0] mfr_code,
                                                input logic [6:0] dev_code,
                                                input logic [6:0] cont_code);
    logic [6:0] low7;
    low7 = a1 ? (a0 ? dev_code : mfr_code) : cont_code;
    return {~(^low7), low7};
  endfunction

  // One-time programming can only clear bits
  function automatic logic [BYTE_W-1:0] merge_prog(input logic [BYTE_W-1:0] old_b,
                                                   input logic [BYTE_W-1:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chip_sel_n,
  input  logic      out_en_n,
  input  logic      prog_n,
  input  logic      vpp_hi,
  input  logic      id_hv,
  output otp_mode_e mode,
  output logic      is_read,
  output logic      is_prog,
  output logic      is_verify,
  output logic      is_id
);

  always_comb begin
    if (chip_sel_n) begin
      mode = M_STANDBY;
    end else if (vpp_hi) begin
      if (out_en_n && !prog_n)      mode = M_PROGRAM;
      else if (!out_en_n && prog_n) mode = M_VERIFY;
      else                          mode = M_DISABLE;
    end else if (out_en_n) begin
      mode = M_DISABLE;
    end else if (id_hv) begin
      mode = M_ID;
    end else begin
      mode = M_READ;
    end
  end

  assign is_read   = (mode == M_READ);
  assign is_prog   = (mode == M_PROGRAM);
  assign is_verify = (mode == M_VERIFY);
  assign is_id     = (mode == M_ID);

  // R4: chip select high never yields a driving or writing mode
  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel_n |-> !(is_read || is_prog || is_verify || is_id));

  assert_one_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_read, is_prog, is_verify, is_id}));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[i] <= '1;
        end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
          mem_q[i] <= merge_prog(mem_q[i], wr_data);
        end
      end

      // R2: a cleared bit never comes back
      assert_no_regrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_q[i] & ~$past(mem_q[i])) == '0);
    end
  endgenerate

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux
  import otp_pkg::*;
#(
  parameter logic [6:0] MFR_CODE  = 7'h1C,
  parameter logic [6:0] DEV_CODE  = 7'h02,
  parameter logic [6:0] CONT_CODE = 7'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  otp_mode_e         mode,
  input  logic              a1,
  input  logic              a0,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe
);

  always_comb begin
    dout    = '0;
    dout_oe = 1'b0;
    unique case (mode)
      M_READ, M_VERIFY: begin
        dout    = rd_data;
        dout_oe = 1'b1;
      end
      M_ID: begin
        dout    = id_byte(a1, a0, MFR_CODE, DEV_CODE, CONT_CODE);
        dout_oe = 1'b1;
      end
      default: begin
        dout    = '0;
        dout_oe = 1'b0;
      end
    endcase
  end

  // R9: ID bytes carry odd parity
  assert_id_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ID) |-> ($countones(dout) % 2 == 1));

  assert_release_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_pkg::*;
#(
  parameter int         ADDR_W    = 5,
  parameter logic [6:0] MFR_CODE  = 7'h1C,
  parameter logic [6:0] DEV_CODE  = 7'h02,
  parameter logic [6:0] CONT_CODE = 7'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              prog_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);

  otp_mode_e         mode;
  logic              is_read, is_prog, is_verify, is_id;
  logic              prog_q;
  logic              wr_en;
  logic [BYTE_W-1:0] rd_data;

  otp_mode_decode u_decode (
    .clk(clk), .rst_n(rst_n),
    .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .prog_n(prog_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv),
    .mode(mode), .is_read(is_read), .is_prog(is_prog),
    .is_verify(is_verify), .is_id(is_id)
  );

  // Strobe history: a write needs the strobe high on the previous sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= 1'b1;
    else        prog_q <= prog_n;
  end

  assign wr_en = is_prog && prog_q;

  otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(din),
    .rd_addr(addr), .rd_data(rd_data)
  );

  otp_out_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .CONT_CODE(CONT_CODE)) u_out (
    .clk(clk), .rst_n(rst_n),
    .mode(mode), .a1(addr[1]), .a0(addr[0]),
    .rd_data(rd_data), .dout(dout), .dout_oe(dout_oe)
  );

  // R5: writes only with the pins in program mode
  assert_write_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (vpp_hi && !chip_sel_n && out_en_n && !prog_n));

  // R10: one write per strobe fall
  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: tb/otp_mode_ctrl_tb_top.sv
module otp_mode_ctrl_tb_top;

  localparam int ADDR_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              chip_sel_n = 1'b1, out_en_n = 1'b1, prog_n = 1'b1;
  logic              vpp_hi = 1'b0, id_hv = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        din = '0;
  logic [7:0]        dout;
  logic              dout_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] model [DEPTH];
  logic       prev_prog = 1'b1;

  always #5 clk = ~clk;

  otp_mode_ctrl #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .prog_n(prog_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [8:0] expect_out(input logic cs, input logic oe, input logic pg,
                                            input logic vp, input logic hv,
                                            input logic [ADDR_W-1:0] a);
    if (cs) return 9'h000;
    if (vp) return (!oe && pg) ? {1'b1, model[a]} : 9'h000;
    if (oe) return 9'h000;
    if (hv) return {1'b1, a[1] ? (a[0] ? 8'h02 : 8'h1C) : 8'h7F};
    return {1'b1, model[a]};
  endfunction

  task automatic check(input string tag, input logic [8:0] exp);
    checks++;
    if ({dout_oe, dout} !== exp) begin
      failures++;
      $display("FAIL %s actual oe=%b d=%h expected oe=%b d=%h", tag, dout_oe, dout, exp[8], exp[7:0]);
    end
  endtask

  task automatic step(input logic cs, input logic oe, input logic pg, input logic vp,
                      input logic hv, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                      input string tag);
    @(negedge clk);
    chip_sel_n = cs; out_en_n = oe; prog_n = pg; vpp_hi = vp; id_hv = hv; addr = a; din = d;
    #1;
    check(tag, expect_out(cs, oe, pg, vp, hv, a));
    if (!cs && !vp && !oe && hv) begin
      checks++;
      if ($countones(dout) % 2 != 1) begin
        failures++;
        $display("FAIL R9 parity actual d=%h expected odd ones", dout);
      end
    end
    @(posedge clk);
    if (prev_prog && !pg && !cs && oe && vp) model[a] = model[a] & d;
    prev_prog = pg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 check("R4 reset standby", 9'h000);
    @(negedge clk) rst_n = 1'b1;

    step(1, 0, 1, 0, 0, 5'd3, 8'h00, "R4 standby oe low");
    step(0, 0, 1, 0, 0, 5'd3, 8'h00, "R1 R3 erased read");
    check("R1 explicit FF", 9'h1FF);
    step(0, 1, 1, 0, 0, 5'd3, 8'h00, "R4 oe high");
    // program 0xF0 then 0x3C at address 3 -> 0x30
    step(0, 1, 1, 1, 0, 5'd3, 8'hF0, "R4 prog setup");
    step(0, 1, 0, 1, 0, 5'd3, 8'hF0, "R4 R5 program hiZ");
    step(0, 1, 1, 1, 0, 5'd3, 8'h3C, "R5 strobe up");
    step(0, 1, 0, 1, 0, 5'd3, 8'h3C, "R2 second write");
    step(0, 0, 1, 1, 0, 5'd3, 8'h00, "R2 R6 verify");
    check("R2 explicit 30", 9'h130);
    // try to restore ones
    step(0, 1, 0, 1, 0, 5'd3, 8'hFF, "R2 setup");
    step(0, 1, 1, 1, 0, 5'd3, 8'hFF, "R2 strobe up");
    step(0, 1, 0, 1, 0, 5'd3, 8'hFF, "R2 write ones");
    step(0, 0, 1, 0, 0, 5'd3, 8'h00, "R2 R3 still 30");
    check("R2 no regrow", 9'h130);
    // held strobe: addr 7
    step(0, 1, 1, 1, 0, 5'd7, 8'hF0, "R10 setup");
    step(0, 1, 0, 1, 0, 5'd7, 8'hF0, "R10 fall");
    step(0, 1, 0, 1, 0, 5'd7, 8'h00, "R10 held");
    step(0, 1, 0, 1, 0, 5'd7, 8'h0F, "R10 held");
    step(0, 0, 1, 1, 0, 5'd7, 8'h00, "R10 verify");
    check("R10 single write F0", 9'h1F0);
    // strobe falls outside program mode (oe low), then oe rises
    step(0, 0, 0, 1, 0, 5'd9, 8'h00, "R4 R10 vpp other");
    step(0, 1, 0, 1, 0, 5'd9, 8'h00, "R10 no edge");
    step(0, 0, 1, 1, 0, 5'd9, 8'h00, "R10 verify FF");
    check("R10 missed edge", 9'h1FF);
    // inhibit with chip select high
    step(1, 1, 1, 1, 0, 5'd11, 8'h00, "R5 inhibit setup");
    step(1, 1, 0, 1, 0, 5'd11, 8'h00, "R5 inhibit fall");
    step(0, 0, 1, 0, 0, 5'd11, 8'h00, "R5 inhibited read");
    check("R5 inhibit FF", 9'h1FF);
    // ID bytes
    step(0, 0, 1, 0, 1, 5'b11110, 8'h00, "R7 mfr");
    check("R7 mfr 1C", 9'h11C);
    step(0, 0, 1, 0, 1, 5'b11111, 8'h00, "R7 dev");
    check("R7 dev 02", 9'h102);
    step(0, 0, 1, 0, 1, 5'b11100, 8'h00, "R8 cont a0=0");
    check("R8 7F", 9'h17F);
    step(0, 0, 1, 0, 1, 5'b11101, 8'h00, "R8 cont a0=1");
    check("R8 7F", 9'h17F);
    step(1, 0, 1, 0, 1, 5'b11110, 8'h00, "R4 id standby");

    for (int n = 0; n < 600; n++) begin
      step(($urandom % 4) == 0, ($urandom % 2) == 1, ($urandom % 2) == 1,
           ($urandom % 2) == 1, ($urandom % 4) == 0, ADDR_W'($urandom % DEPTH),
           8'($urandom), "R2 R3 R4 R5 R6 random");
    end
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 1, 0, 0, ADDR_W'(i), 8'h00, "R3 final sweep");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule